// File: doc/BRIEF.md
# Hot-swap bus connect controller

This block decides when the two halves of a buffered two-wire serial bus may be joined. A card plugged into a live backplane must not join its local segment in the middle of a transfer. The controller therefore keeps the repeater drivers off while either supply is unhealthy or the enable input is low. After a timed settling period, it watches the sampled bus levels for a safe moment to join.

Two events count as a safe moment. The first is a STOP condition on the A side, with every line high. The second is a stretch in which all four lines (data and clock on both sides) stay high for a programmable quiet time. Whichever event comes first sets the single `connect` output, which gates the repeater drivers. The output stays set until the enable or a supply flag drops. The settling time and the quiet time are parameters counted in clock cycles. All four line inputs pass through two-stage synchronisers before any edge is detected.

Top module: `bus_join_ctrl`

## Requirements
- R1: While `supply_a_good` or `supply_b_good` is 0 at a clock edge, `connect` reads 0 after that edge.
- R2: `enable` at 0 at a clock edge forces the disconnected state after that edge, from any state. This holds even when a join would otherwise have been taken at that same edge.
- R3: Suppose `enable` and both supply flags are 1 at an edge, and at least one of them was 0 before. The block then spends INIT_CYCLES edges in settling before it starts watching the bus. With a quiet bus, `connect` rises after exactly INIT_CYCLES+IDLE_CYCLES+1 edges, counting the edge that first saw all three high.
- R4: Bus activity before or during settling does not count toward a join. Quiet-time counting and STOP detection start only once settling ends.
- R5: While watching, `connect` rises one edge after the synchronised lines have been all high on IDLE_CYCLES consecutive edges.
- R6: While watching, a STOP joins the bus. A STOP is a synchronised 0-to-1 change of `sda_a_in` seen while `scl_a_in`, `sda_b_in` and `scl_b_in` are all 1. When `scl_a_in` is 0, a rise of `sda_a_in` does not join.
- R7: When enabled on a busy bus, the block joins at the first STOP or at the first long-enough quiet gap, whichever happens first.
- R8: A low level on any of the four lines restarts the quiet-time count from zero, even for a single cycle.
- R9: Each line input passes through two flip-flops. A line change driven before edge r0 can therefore first change `connect` at edge r2 (via a STOP) or at edge r(IDLE_CYCLES+1) (via quiet time).
- R10: Once `connect` is 1, it stays 1 whatever the lines do, for as long as `enable` and both supply flags stay 1.
- R11: Reset drives `connect` to 0 and clears all counters and synchronisers. Synchronised lines read as low until they are refilled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_a_good | input | 1 | Low-voltage side supply healthy, 1 = good |
| supply_b_good | input | 1 | High-voltage side supply healthy, 1 = good |
| enable | input | 1 | Active-high join permission |
| sda_a_in | input | 1 | Sampled data level, A side |
| scl_a_in | input | 1 | Sampled clock level, A side |
| sda_b_in | input | 1 | Sampled data level, B side |
| scl_b_in | input | 1 | Sampled clock level, B side |
| connect | output | 1 | 1 = repeater drivers allowed to join the two halves |

## Verification
A join request and a loss of permission can land on the same clock edge. The quiet-time count can complete at the very edge where `enable` falls or a supply flag drops. The bench provokes this by releasing `enable` on the negative edge just before the edge at which the quiet count would complete. It expects `connect` to stay 0, because the disconnect takes priority. A cycle-accurate bench model also runs random bursts of traffic, quiet gaps, STOP patterns and permission glitches, so any other coincidences of this kind are compared edge by edge.

// File: rtl/bus_join_pkg.sv
package bus_join_pkg;

  typedef enum logic [1:0] {
    JS_OFF    = 2'd0,
    JS_INIT   = 2'd1,
    JS_WATCH  = 2'd2,
    JS_JOINED = 2'd3
  } join_state_e;

  localparam int LINE_COUNT = 4;
  localparam int LN_SDA_A   = 0;
  localparam int LN_SCL_A   = 1;
  localparam int LN_SDA_B   = 2;
  localparam int LN_SCL_B   = 3;

  // width of a counter that holds 0 .. limit-1
  function automatic int ctr_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // true when a 0-based count sits on its final value
  function automatic logic at_last(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/bus_join_sync.sv
module bus_join_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/bus_join_quiet.sv
module bus_join_quiet
  import bus_join_pkg::*;
#(
  parameter int IDLE_CYCLES = 12500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic [LINE_COUNT-1:0] lines,
  output logic                  stop_evt,
  output logic                  idle_done
);

  localparam int CW = ctr_bits(IDLE_CYCLES);

  logic [CW-1:0] idle_cnt;
  logic          sda_a_q;
  logic          all_high;
  logic          sda_a_rise;
  logic          cnt_full;

  assign all_high   = &lines;
  assign sda_a_rise = lines[LN_SDA_A] & ~sda_a_q;
  assign cnt_full   = at_last(32'(idle_cnt), IDLE_CYCLES);

  // STOP: data rises with every other line high (clock high included)
  assign stop_evt  = arm & all_high & sda_a_rise;
  assign idle_done = arm & all_high & cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_a_q  <= 1'b0;
      idle_cnt <= '0;
    end else begin
      sda_a_q <= lines[LN_SDA_A];
      if (!arm || !all_high) idle_cnt <= '0;
      else if (!cnt_full)    idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R8: any low line restarts the quiet count
  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !all_high) |=> (idle_cnt == '0));

  // R6: a STOP needs the A clock high and a fresh data rise
  assert_stop_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> (lines[LN_SCL_A] && !$past(lines[LN_SDA_A])));

  // R5: completion of a multi-cycle quiet run was preceded by a quiet, armed cycle
  assert_idle_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_done && (IDLE_CYCLES > 1)) |-> ($past(all_high) && $past(arm)));

endmodule

// File: rtl/bus_join_fsm.sv
module bus_join_fsm
  import bus_join_pkg::*;
#(
  parameter int INIT_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_a_ok,
  input  logic pwr_b_ok,
  input  logic enable,
  input  logic join_req,
  output logic arm,
  output logic connect
);

  localparam int CW = ctr_bits(INIT_CYCLES);

  join_state_e   state, state_nx;
  logic [CW-1:0] init_cnt;
  logic          go;
  logic          init_last;

  assign go        = pwr_a_ok & pwr_b_ok & enable;
  assign init_last = at_last(32'(init_cnt), INIT_CYCLES);

  always_comb begin
    state_nx = state;
    if (!go) begin
      state_nx = JS_OFF;
    end else begin
      case (state)
        JS_OFF:    state_nx = JS_INIT;
        JS_INIT:   if (init_last) state_nx = JS_WATCH;
        JS_WATCH:  if (join_req)  state_nx = JS_JOINED;
        JS_JOINED: state_nx = JS_JOINED;
        default:   state_nx = JS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= JS_OFF;
      init_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state != JS_INIT)  init_cnt <= '0;
      else if (!init_last)   init_cnt <= init_cnt + 1'b1;
    end
  end

  assign arm     = (state == JS_WATCH);
  assign connect = (state == JS_JOINED);

  assert_pwr_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_a_ok || !pwr_b_ok) |=> !connect);

  assert_enable_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == JS_OFF));

  assert_init_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm) |-> ($past(state) == JS_INIT));

  assert_join_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect) |-> ($past(arm) && $past(join_req)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (connect && go) |=> connect);

endmodule

// File: rtl/bus_join_ctrl.sv
module bus_join_ctrl
  import bus_join_pkg::*;
#(
  parameter int INIT_CYCLES = 25000,
  parameter int IDLE_CYCLES = 12500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_a_good,
  input  logic supply_b_good,
  input  logic enable,
  input  logic sda_a_in,
  input  logic scl_a_in,
  input  logic sda_b_in,
  input  logic scl_b_in,
  output logic connect
);

  logic [LINE_COUNT-1:0] raw_lines;
  logic [LINE_COUNT-1:0] sync_lines;
  logic                  arm;
  logic                  stop_evt;
  logic                  idle_done;
  logic                  join_req;

  assign raw_lines[LN_SDA_A] = sda_a_in;
  assign raw_lines[LN_SCL_A] = scl_a_in;
  assign raw_lines[LN_SDA_B] = sda_b_in;
  assign raw_lines[LN_SCL_B] = scl_b_in;

  bus_join_sync #(
    .WIDTH (LINE_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_lines),
    .dout (sync_lines)
  );

  bus_join_quiet #(
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_quiet (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .lines    (sync_lines),
    .stop_evt (stop_evt),
    .idle_done(idle_done)
  );

  assign join_req = stop_evt | idle_done;

  bus_join_fsm #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_a_ok(supply_a_good),
    .pwr_b_ok(supply_b_good),
    .enable  (enable),
    .join_req(join_req),
    .arm     (arm),
    .connect (connect)
  );

  // R4: a join request never appears outside the watch phase
  assert_req_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    join_req |-> arm);

endmodule

// File: tb/bus_join_ctrl_tb.sv
module bus_join_ctrl_tb;

  localparam int INIT = 20;
  localparam int IDLE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b1, pb = 1'b1, en = 1'b0;
  logic [3:0] ln = 4'hF;   // {scl_b, sda_b, scl_a, sda_a}
  logic connect;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_join_ctrl #(.INIT_CYCLES(INIT), .IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_a_good(pa), .supply_b_good(pb),
    .enable(en), .sda_a_in(ln[0]), .scl_a_in(ln[1]), .sda_b_in(ln[2]),
    .scl_b_in(ln[3]), .connect(connect));

  // expected edge counts, stated from the requirements
  function automatic int fresh_join_edges();
    return INIT + IDLE + 1;             // R3
  endfunction
  function automatic int quiet_join_edges();
    return IDLE + 2;                    // R5, R9
  endfunction
  function automatic int stop_join_edges();
    return 3;                           // R6, R9
  endfunction

  // cycle model: phase 0 off, 1 settling, 2 watching, 3 joined
  logic [3:0] m_s1, m_s2;
  logic m_prev;
  int m_phase, m_tmr, m_run;
  bit model_live = 0;

  always @(posedge clk or negedge rst_n) begin
    logic ok, quiet, stop_now, idle_now;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = 1'b0;
      m_phase = 0; m_tmr = 0; m_run = 0;
    end else begin
      ok       = pa & pb & en;
      quiet    = (m_s2 == 4'hF);
      stop_now = quiet && m_s2[0] && !m_prev;
      idle_now = (m_phase == 2) && quiet && (m_run == IDLE - 1);
      if (m_phase == 2 && quiet) begin
        if (m_run < IDLE - 1) m_run++;
      end else m_run = 0;
      if (!ok) m_phase = 0;
      else if (m_phase == 0) begin m_phase = 1; m_tmr = 0; end
      else if (m_phase == 1) begin
        if (m_tmr == INIT - 1) m_phase = 2; else m_tmr++;
      end else if (m_phase == 2) begin
        if (stop_now || idle_now) m_phase = 3;
      end
      m_prev = m_s2[0];
      m_s2 = m_s1;
      m_s1 = ln;
    end
  end

  always @(negedge clk) begin
    if (model_live) begin
      checks++;
      if (connect !== (m_phase == 3)) begin
        bad++;
        $display("FAIL model R1 R2 R5 R6 R7 R10 t=%0t actual=%0b expected=%0b",
                 $time, connect, (m_phase == 3));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (connect !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, connect, exp, $time);
    end
  endtask

  task automatic recycle();
    en = 1'b0;
    tick(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    tick(4);
    check(1'b0, "R11 during reset");
    rst_n = 1'b1;
    tick(1);
    check(1'b0, "R11 after reset");
    model_live = 1;
    tick(4);

    // R3 / R5: quiet bus, fresh enable
    en = 1'b1;
    tick(fresh_join_edges() - 1);
    check(1'b0, "R3 one edge early");
    tick(1);
    check(1'b1, "R3 exact join");

    // R10: traffic after joining
    for (int i = 0; i < 50; i++) begin
      ln = 4'($urandom);
      tick(1);
      check(1'b1, "R10 hold under traffic");
    end
    ln = 4'hF;
    tick(3);

    // R2: enable drop
    en = 1'b0;
    tick(1);
    check(1'b0, "R2 disable");

    // R1: supply drop while joined, then restore
    en = 1'b1;
    tick(fresh_join_edges());
    check(1'b1, "R1 setup joined");
    pa = 1'b0;
    tick(1);
    check(1'b0, "R1 supply A drop");
    pa = 1'b1;
    tick(fresh_join_edges() - 1);
    check(1'b0, "R1 R3 rejoin early");
    tick(1);
    check(1'b1, "R1 R3 rejoin");

    // R4 / R5 / R9: busy bus during settling
    recycle();
    ln[3] = 1'b0;
    en = 1'b1;
    tick(INIT + IDLE + 5);
    check(1'b0, "R4 busy through settling");
    ln[3] = 1'b1;
    tick(quiet_join_edges() - 1);
    check(1'b0, "R9 quiet one edge early");
    tick(1);
    check(1'b1, "R5 quiet join");

    // R8: one-cycle glitch restarts the count
    recycle();
    ln[3] = 1'b0;
    en = 1'b1;
    tick(INIT + 5);
    ln[3] = 1'b1;
    tick(IDLE / 2);
    ln[2] = 1'b0;
    tick(1);
    ln[2] = 1'b1;
    tick(quiet_join_edges() - 1);
    check(1'b0, "R8 count restarted");
    tick(1);
    check(1'b1, "R8 join after restart");

    // R6 / R7: STOP joins before quiet time expires
    recycle();
    ln[0] = 1'b0;
    en = 1'b1;
    tick(INIT + 5);
    check(1'b0, "R6 data low, no join");
    ln[0] = 1'b1;
    tick(stop_join_edges() - 1);
    check(1'b0, "R9 stop one edge early");
    tick(1);
    check(1'b1, "R7 stop join first");

    // R6 negative: data rise with clock low
    recycle();
    ln[0] = 1'b0;
    ln[1] = 1'b0;
    en = 1'b1;
    tick(INIT + 5);
    ln[0] = 1'b1;
    tick(stop_join_edges() + 1);
    check(1'b0, "R6 no stop with clock low");
    ln[1] = 1'b1;
    tick(quiet_join_edges() - 1);
    check(1'b0, "R7 quiet path early");
    tick(1);
    check(1'b1, "R7 quiet path join");

    // R2: enable falls on the edge where the quiet count completes
    recycle();
    en = 1'b1;
    tick(fresh_join_edges() - 1);
    check(1'b0, "R2 before collision");
    en = 1'b0;
    tick(1);
    check(1'b0, "R2 disable beats join");
    tick(IDLE);
    check(1'b0, "R2 stays off");

    // random segments checked by the model
    for (int seg = 0; seg < 200; seg++) begin
      int len, mode;
      len  = 1 + ($urandom % 40);
      mode = $urandom % 3;
      for (int c = 0; c < len; c++) begin
        case (mode)
          0: ln = 4'hF;
          1: ln = 4'($urandom);
          default: ln = {3'b111, (c >= len / 2)};
        endcase
        pa = ($urandom % 300) != 0;
        pb = ($urandom % 300) != 0;
        if (($urandom % 120) == 0) en = ~en;
        else if (!en && ($urandom % 10) == 0) en = 1'b1;
        tick(1);
      end
    end

    model_live = 0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule